// File: doc/BRIEF.md
# Temperature limit status monitor

This block checks a local and a remote signed 8-bit temperature against programmable limits each time a monitor strobe arrives. The results go into sticky flags in two status bytes. A host clears a byte by pulsing its read strobe. The block also drives an active-low over-temperature output, an active-low overtemperature-shutdown output and a level-sensitive alert request.

Each flag follows its own rule for clearing and setting again:
- The limit, passive and critical flags set again on the next strobe if their condition still holds.
- The over-temperature flags need the temperature to cool by a hysteresis margin after a read before they can set again.
- The remote-sensor fault flag ignores reads and clears only on reset. While it is set, the remote reading is replaced by -128.

A flag that sets in the same cycle as a read of its byte stays set, so no event is lost.

Top module: `tmon_status`

## Requirements
- R1: Flags change only on a cycle with `mon_tick_i` high, or on a read of their byte. Input changes without a strobe leave both bytes unchanged.
- R2: Low flags set on a strobe when temperature <= low limit (signed). Local is `stat1_o[7]` and remote is `stat1_o[3]`.
- R3: High flags set on a strobe when temperature >= high limit (signed). Local is `stat1_o[6]` and remote is `stat1_o[2]`.
- R4: A read strobe clears every clearable bit of its byte in the next cycle. A flag whose condition still holds sets again on the next strobe. A strobe and a read in the same cycle leave the flag set.
- R5: Remote fault flag `stat1_o[5]`:
  - It sets on a strobe with `rem_fault_i` high and holds until reset, whatever reads follow.
  - While the flag is set, or `rem_fault_i` is high, the remote value used and shown on `rem_temp_o` is -128 (0x80).
  - The flag holds `ovr_no` low.
- R6: Over-temperature flags set on a strobe when temperature > its limit (strictly). Local is `stat2_o[6]` and remote is `stat1_o[4]`. `therm_no` is low while either flag is set.
- R7: After a read clears a set over-temperature flag, that flag cannot set again until a strobe sees temperature <= limit - 5.
- R8: Critical flags set on a strobe when temperature >= critical limit. Local is `stat2_o[4]` and remote is `stat2_o[3]`. Either one drives `ovr_no` low and `alert_o` high, whatever the enables are.
- R9: Passive flag `stat2_o[5]` sets on a strobe when the control temperature <= `psv_temp_i`. The control temperature is local when `ctl_src_i`=0 and the effective remote when it is 1.
- R10: `alert_o` is the level OR of the following terms:
  - `ie_lim_i` AND any low or high flag
  - `ie_therm_i` AND any over-temperature flag
  - `ie_psv_i` AND the passive flag
  - `ie_fail_i` AND the fault flag
  - any critical flag
- R11: After reset both bytes are 0x00, `therm_no` and `ovr_no` are high and `alert_o` is low. Bits `stat1_o[1:0]`, `stat2_o[7]` and `stat2_o[2:0]` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mon_tick_i | input | 1 | Monitor cycle strobe |
| loc_temp_i | input | 8 | Local temperature, signed |
| rem_temp_i | input | 8 | Remote temperature, signed |
| rem_fault_i | input | 1 | Remote sensor open or short |
| loc_low_i | input | 8 | Local low limit |
| loc_high_i | input | 8 | Local high limit |
| loc_therm_i | input | 8 | Local over-temperature limit |
| loc_crit_i | input | 8 | Local critical limit |
| rem_low_i | input | 8 | Remote low limit |
| rem_high_i | input | 8 | Remote high limit |
| rem_therm_i | input | 8 | Remote over-temperature limit |
| rem_crit_i | input | 8 | Remote critical limit |
| psv_temp_i | input | 8 | Passive cooling temperature |
| ctl_src_i | input | 1 | Control temperature select (0 local, 1 remote) |
| ie_lim_i | input | 1 | Alert enable, low/high flags |
| ie_therm_i | input | 1 | Alert enable, over-temperature flags |
| ie_psv_i | input | 1 | Alert enable, passive flag |
| ie_fail_i | input | 1 | Alert enable, remote fault flag |
| rd_stat1_i | input | 1 | Read strobe, status byte 1 |
| rd_stat2_i | input | 1 | Read strobe, status byte 2 |
| stat1_o | output | 8 | Status byte 1 |
| stat2_o | output | 8 | Status byte 2 |
| rem_temp_o | output | 8 | Effective remote temperature |
| therm_no | output | 1 | Over-temperature output, active low |
| ovr_no | output | 1 | Shutdown output, active low |
| alert_o | output | 1 | Alert request, level |

## Verification
The bench tests each comparison at its exact limit, including the point where the over-temperature test (strict greater-than) and the high test (greater-or-equal) differ. A design that mixed up those comparisons would flag one reading early or late.

The hysteresis sequence heats, reads, hovers one degree inside the margin, then cools to exactly limit - 5. A design that re-armed too soon, or never re-armed, sets the flag at the wrong step.

The fault test reads the status while the fault is set and then removes the fault. A design that cleared the fault flag on read, or stopped substituting -128, would show it. Strobes that coincide with a read, and enable toggles around the unmaskable critical alert, expose a lost event or a maskable critical path.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
  localparam int TEMP_W = 8;
  localparam int HYST   = 5;
  localparam int NCH    = 2;   // 0 local, 1 remote
  localparam int NFLAG  = 8;

  typedef struct packed {
    logic [TEMP_W-1:0] low;
    logic [TEMP_W-1:0] high;
    logic [TEMP_W-1:0] therm;
    logic [TEMP_W-1:0] crit;
  } lim_t;

  // flag slots
  localparam int F_LLO = 0;
  localparam int F_LHI = 1;
  localparam int F_RLO = 2;
  localparam int F_RHI = 3;
  localparam int F_FLT = 4;
  localparam int F_PSV = 5;
  localparam int F_LCR = 6;
  localparam int F_RCR = 7;
endpackage

// File: rtl/tmon_flag.sv
module tmon_flag #(
  parameter bit HOLD = 1'b0   // 1: ignore read clear
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              q_o <= 1'b0;
    else if (set_i)           q_o <= 1'b1;  // set beats read
    else if (clr_i && !HOLD)  q_o <= 1'b0;
  end
endmodule

// File: rtl/tmon_chan.sv
module tmon_chan
  import tmon_pkg::*;
#(
  parameter int W = TEMP_W,
  parameter int H = HYST
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] temp_i,
  input  lim_t         lim_i,
  input  logic         therm_rd_i,
  output logic         low_o,
  output logic         high_o,
  output logic         crit_o,
  output logic         therm_o
);
  localparam int XW = W + 2;

  logic signed [XW-1:0] t_x, th_x;
  logic therm_c, cool_c, therm_set, arm_q;

  assign t_x  = XW'($signed(temp_i));
  assign th_x = XW'($signed(lim_i.therm));

  assign low_o   = $signed(temp_i) <= $signed(lim_i.low);
  assign high_o  = $signed(temp_i) >= $signed(lim_i.high);
  assign crit_o  = $signed(temp_i) >= $signed(lim_i.crit);
  assign therm_c = $signed(temp_i) >  $signed(lim_i.therm);
  assign cool_c  = (t_x + XW'(H)) <= th_x;

  assign therm_set = tick_i && therm_c && arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      therm_o <= 1'b0;
      arm_q   <= 1'b1;
    end else begin
      if (therm_set)       therm_o <= 1'b1;
      else if (therm_rd_i) therm_o <= 1'b0;
      // disarm on a read that actually clears the flag, re-arm once cooled
      if (tick_i && cool_c)                           arm_q <= 1'b1;
      else if (therm_rd_i && therm_o && !therm_set)   arm_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tmon_status.sv
module tmon_status
  import tmon_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mon_tick_i,
  input  logic [TEMP_W-1:0] loc_temp_i,
  input  logic [TEMP_W-1:0] rem_temp_i,
  input  logic              rem_fault_i,
  input  logic [TEMP_W-1:0] loc_low_i,
  input  logic [TEMP_W-1:0] loc_high_i,
  input  logic [TEMP_W-1:0] loc_therm_i,
  input  logic [TEMP_W-1:0] loc_crit_i,
  input  logic [TEMP_W-1:0] rem_low_i,
  input  logic [TEMP_W-1:0] rem_high_i,
  input  logic [TEMP_W-1:0] rem_therm_i,
  input  logic [TEMP_W-1:0] rem_crit_i,
  input  logic [TEMP_W-1:0] psv_temp_i,
  input  logic              ctl_src_i,
  input  logic              ie_lim_i,
  input  logic              ie_therm_i,
  input  logic              ie_psv_i,
  input  logic              ie_fail_i,
  input  logic              rd_stat1_i,
  input  logic              rd_stat2_i,
  output logic [7:0]        stat1_o,
  output logic [7:0]        stat2_o,
  output logic [TEMP_W-1:0] rem_temp_o,
  output logic              therm_no,
  output logic              ovr_no,
  output logic              alert_o
);
  localparam logic [NFLAG-1:0] HOLD_MASK = NFLAG'(1) << F_FLT;
  localparam logic [TEMP_W-1:0] T_MIN = {1'b1, {(TEMP_W-1){1'b0}}};

  logic [TEMP_W-1:0] temp   [NCH];
  lim_t              lim    [NCH];
  logic [NCH-1:0]    low_c, high_c, crit_c, therm_q, therm_rd;
  logic [NFLAG-1:0]  f_set, f_clr, f_q;
  logic [TEMP_W-1:0] ctl_temp;
  logic              psv_c;

  // remote sensor substitution
  assign rem_temp_o = (rem_fault_i || f_q[F_FLT]) ? T_MIN : rem_temp_i;

  assign temp[0] = loc_temp_i;
  assign temp[1] = rem_temp_o;
  assign lim[0]  = {loc_low_i, loc_high_i, loc_therm_i, loc_crit_i};
  assign lim[1]  = {rem_low_i, rem_high_i, rem_therm_i, rem_crit_i};
  assign therm_rd[0] = rd_stat2_i;
  assign therm_rd[1] = rd_stat1_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tmon_chan u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (mon_tick_i),
      .temp_i     (temp[c]),
      .lim_i      (lim[c]),
      .therm_rd_i (therm_rd[c]),
      .low_o      (low_c[c]),
      .high_o     (high_c[c]),
      .crit_o     (crit_c[c]),
      .therm_o    (therm_q[c])
    );
  end

  assign ctl_temp = ctl_src_i ? rem_temp_o : loc_temp_i;
  assign psv_c    = $signed(ctl_temp) <= $signed(psv_temp_i);

  always_comb begin
    f_set        = '0;
    f_set[F_LLO] = low_c[0];
    f_set[F_LHI] = high_c[0];
    f_set[F_RLO] = low_c[1];
    f_set[F_RHI] = high_c[1];
    f_set[F_FLT] = rem_fault_i;
    f_set[F_PSV] = psv_c;
    f_set[F_LCR] = crit_c[0];
    f_set[F_RCR] = crit_c[1];
    f_set        = f_set & {NFLAG{mon_tick_i}};

    f_clr        = {NFLAG{rd_stat1_i}};
    f_clr[F_PSV] = rd_stat2_i;
    f_clr[F_LCR] = rd_stat2_i;
    f_clr[F_RCR] = rd_stat2_i;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    tmon_flag #(.HOLD(HOLD_MASK[i])) u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (f_set[i]),
      .clr_i  (f_clr[i]),
      .q_o    (f_q[i])
    );
  end

  assign stat1_o = {f_q[F_LLO], f_q[F_LHI], f_q[F_FLT], therm_q[1],
                    f_q[F_RLO], f_q[F_RHI], 2'b00};
  assign stat2_o = {1'b0, therm_q[0], f_q[F_PSV], f_q[F_LCR], f_q[F_RCR], 3'b000};

  assign therm_no = ~|therm_q;
  assign ovr_no   = ~(f_q[F_LCR] | f_q[F_RCR] | f_q[F_FLT]);
  assign alert_o  = (ie_lim_i   && |{f_q[F_LLO], f_q[F_LHI], f_q[F_RLO], f_q[F_RHI]})
                 || (ie_therm_i && |therm_q)
                 || (ie_psv_i   && f_q[F_PSV])
                 || (ie_fail_i  && f_q[F_FLT])
                 || f_q[F_LCR] || f_q[F_RCR];
endmodule

// File: rtl/tmon_checker.sv
module tmon_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mon_tick_i,
  input logic       rd_stat1_i,
  input logic       rd_stat2_i,
  input logic [7:0] stat1_o,
  input logic [7:0] stat2_o,
  input logic [7:0] rem_temp_o,
  input logic       therm_no,
  input logic       ovr_no,
  input logic       alert_o
);
  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mon_tick_i && !rd_stat1_i) |=> $stable(stat1_o));

  assert_read_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat2_i && !mon_tick_i) |=> (stat2_o == 8'h00));

  assert_fault_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat1_o[5] |=> stat1_o[5]);

  assert_fault_out_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat1_o[5] |-> (!ovr_no && rem_temp_o == 8'h80));

  assert_therm_pin_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat2_o[6] || stat1_o[4]) |-> !therm_no);

  assert_crit_alert_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat2_o[4] || stat2_o[3]) |-> (alert_o && !ovr_no));

  assert_unused_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat1_o[1:0] == 2'b00 && stat2_o[7] == 1'b0 && stat2_o[2:0] == 3'b000));
endmodule

bind tmon_status tmon_checker u_chk (.*);

// File: tb/tb_tmon_status.sv
`timescale 1ns/1ps
module tb_tmon_status;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic mon_tick_i = 1'b0, rem_fault_i = 1'b0, ctl_src_i = 1'b0;
  logic ie_lim_i = 1'b0, ie_therm_i = 1'b0, ie_psv_i = 1'b0, ie_fail_i = 1'b0;
  logic rd_stat1_i = 1'b0, rd_stat2_i = 1'b0;
  logic [7:0] loc_temp_i = 8'd40, rem_temp_i = 8'd20;
  logic [7:0] loc_low_i = 8'd10, loc_high_i = 8'd60, loc_therm_i = 8'd70, loc_crit_i = 8'd90;
  logic [7:0] rem_low_i = 8'd0, rem_high_i = 8'd50, rem_therm_i = 8'd80, rem_crit_i = 8'd100;
  logic [7:0] psv_temp_i = 8'd30;
  logic [7:0] stat1_o, stat2_o, rem_temp_o;
  logic therm_no, ovr_no, alert_o;

  int tests = 0, fails = 0;

  always #4 clk_i = ~clk_i;

  tmon_status dut (.*);

  // {loc, rem, exp stat1, exp stat2}
  localparam logic [31:0] VEC [0:8] = '{
    32'h19_14_00_20, 32'h28_14_00_00, 32'h0A_00_88_20,
    32'h3C_32_44_00, 32'h47_51_54_40, 32'h5A_64_44_18,
    32'hFB_EC_88_20, 32'h46_50_44_00, 32'h80_7F_94_28
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    mon_tick_i = 1'b1;
    @(negedge clk_i);
    mon_tick_i = 1'b0;
  endtask

  task automatic rd_both();
    rd_stat1_i = 1'b1; rd_stat2_i = 1'b1;
    @(negedge clk_i);
    rd_stat1_i = 1'b0; rd_stat2_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11 reset stat", {stat1_o, stat2_o}, 16'h0000);
    chk("R11 reset pins", {therm_no, ovr_no, alert_o}, 3'b110);

    // R1: no strobe, no change
    loc_temp_i = 8'd5; rem_temp_i = 8'hF6;
    repeat (5) @(negedge clk_i);
    chk("R1 no tick", {stat1_o, stat2_o}, 16'h0000);

    // R4: strobe and read together, set wins
    mon_tick_i = 1'b1; rd_stat1_i = 1'b1; rd_stat2_i = 1'b1;
    @(negedge clk_i);
    mon_tick_i = 1'b0; rd_stat1_i = 1'b0; rd_stat2_i = 1'b0;
    chk("R4 set beats read", {stat1_o, stat2_o}, 16'h8820);
    rd_both();
    chk("R4 read clears", {stat1_o, stat2_o}, 16'h0000);

    // table: R2 R3 R6 R8 R9, then R4 clear
    for (int i = 0; i < 9; i++) begin
      loc_temp_i = VEC[i][31:24];
      rem_temp_i = VEC[i][23:16];
      tick();
      chk($sformatf("R2 R3 R6 R8 R9 vec%0d", i), {stat1_o, stat2_o}, VEC[i][15:0]);
      rd_both();
      chk($sformatf("R4 clear vec%0d", i), {stat1_o, stat2_o}, 16'h0000);
    end

    // R6 / R7 hysteresis on the local channel
    rem_temp_i = 8'd20;
    loc_temp_i = 8'd75; tick();
    chk("R6 local therm set", {stat2_o[6], therm_no}, 2'b10);
    rd_both();
    chk("R6 therm pin released", {stat2_o[6], therm_no}, 2'b01);
    tick();
    chk("R7 no reassert while hot", stat2_o[6], 1'b0);
    rd_both();
    loc_temp_i = 8'd66; tick(); rd_both();
    loc_temp_i = 8'd75; tick();
    chk("R7 no rearm at limit-4", stat2_o[6], 1'b0);
    rd_both();
    loc_temp_i = 8'd65; tick();
    chk("R7 cool step no set", stat2_o[6], 1'b0);
    rd_both();
    loc_temp_i = 8'd75; tick();
    chk("R7 reassert after cooling", stat2_o[6], 1'b1);
    rd_both();

    // R8 critical alert with all enables off
    loc_temp_i = 8'd95; tick();
    chk("R8 crit alert unmasked", {stat2_o[4], alert_o, ovr_no}, 3'b110);
    rd_both();
    chk("R8 crit cleared", {alert_o, ovr_no}, 2'b01);

    // R9 / R10 passive and enables
    loc_temp_i = 8'd25; tick();
    chk("R10 psv masked", {stat2_o[5], alert_o}, 2'b10);
    ie_psv_i = 1'b1; #1;
    chk("R10 psv enabled", alert_o, 1'b1);
    ie_psv_i = 1'b0; rd_both();
    loc_temp_i = 8'd5; tick();
    chk("R10 limit masked", {stat1_o[7], alert_o}, 2'b10);
    ie_lim_i = 1'b1; #1;
    chk("R10 limit enabled", alert_o, 1'b1);
    ie_lim_i = 1'b0; rd_both();
    ctl_src_i = 1'b1; loc_temp_i = 8'd40; rem_temp_i = 8'd20; tick();
    chk("R9 remote control temp", stat2_o[5], 1'b1);
    rd_both(); ctl_src_i = 1'b0;

    // R5 remote fault
    rem_fault_i = 1'b1; tick();
    chk("R5 fault set", stat1_o, 8'h28);
    chk("R5 forced value", rem_temp_o, 8'h80);
    chk("R5 ovr and masked alert", {ovr_no, alert_o}, 2'b00);
    ie_fail_i = 1'b1; #1;
    chk("R10 fault enabled", alert_o, 1'b1);
    ie_fail_i = 1'b0;
    rd_both();
    chk("R5 fault survives read", stat1_o, 8'h20);
    rem_fault_i = 1'b0; tick();
    chk("R5 still forced", {stat1_o, rem_temp_o}, 16'h2880);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11 reset clears fault", {stat1_o, stat2_o, rem_temp_o}, 24'h000014);
    chk("R11 reset pins again", {therm_no, ovr_no, alert_o}, 3'b110);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule